// File: doc/BRIEF.md
# Masked Circular-Queue Address Generator

This block forms the memory operand address for a multiply-accumulate datapath from an address-register value and one of four addressing modes: plain indirect, post-increment, pre-decrement and indirect with a signed displacement. It also produces the updated register value and a write-back strobe for the two auto-stepping modes. Instruction decode, the register file and the memory access are handled elsewhere.

Each request carries a mask-enable bit. When that bit is set, the low half of an address is ANDed with a software-written mask register and the upper half passes through unchanged. Clearing mask bits limits an address to a power-of-two window. Each mode decides whether the mask applies to the operand address, to the updated register, or to both. This lets a post-incremented pointer walk a data array as a circular queue without any wrap logic in software. Results are registered and appear one clock after the request.

Top module: `cq_addr_gen`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` and `rsp_wb` are 0, both address outputs are 0, and the mask register holds all ones. A masked request made before any mask write therefore gives the same result as an unmasked one.
- R2: With `req_mask_en` = 0, the results depend on `req_mode`:
  - indirect (mode 0): operand address = An, new An = An.
  - post-increment (mode 1): operand address = An, new An = An + 4.
  - pre-decrement (mode 2): operand address and new An are both An − 4.
  - displacement (mode 3): operand address = An + sign-extended displacement, new An = An.
- R3: Masked indirect (mode 0): operand address = An & {all ones, MASK}, and new An = An.
- R4: Masked post-increment (mode 1): operand address = An, unmasked. New An = (An + 4) & {all ones, MASK}.
- R5: Masked pre-decrement (mode 2): operand address and new An are both (An − 4) & {all ones, MASK}.
- R6: Masked displacement (mode 3): operand address = (An + sign-extended `req_disp`) & {all ones, MASK}, and new An = An.
- R7: The mask only ever clears bits below position MASK_W. Address bits at MASK_W and above always equal those of the unmasked sum.
- R8: `rsp_valid` is asserted exactly one cycle after `req_valid`. `rsp_wb` is asserted in that same cycle, and only for modes 1 and 2. A cycle with no request leaves both strobes at 0 and the address outputs unchanged.
- R9: A mask written in the same cycle as a request does not affect that request. It applies from the next request on.
- R10: All address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr_en | input | 1 | Load the mask register |
| mask_wr_data | input | MASK_W | New mask value |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 0 indirect, 1 post-increment, 2 pre-decrement, 3 displacement |
| req_areg | input | ADDR_W | Current address-register value |
| req_disp | input | DISP_W | Signed displacement (mode 3) |
| req_mask_en | input | 1 | Apply the mask to this request |
| rsp_valid | output | 1 | Result present |
| rsp_oper_addr | output | ADDR_W | Operand effective address |
| rsp_areg_new | output | ADDR_W | Updated address-register value |
| rsp_wb | output | 1 | Write `rsp_areg_new` back to the register |

## Verification
The bench builds the block with ADDR_W = 12, MASK_W = 8 and DISP_W = 8. At that size every register value from 0 to 4095 can be swept under all four modes, both mask-enable settings and three mask values, including the reset-default mask. The 4-bit upper field lets the pass-through rule and the wrap at both ends of the address space be checked on every request. Displacements are derived from the address so that both signs occur, and directed sequences cover a mask write coinciding with a request, as well as idle cycles.

// File: rtl/cq_agen_pkg.sv
// Shared definitions for the masked circular-queue address generator.
// Assumes the mode field is two bits wide and encoded as below.
package cq_agen_pkg;

    typedef enum logic [1:0] {
        MODE_IND  = 2'd0,
        MODE_POST = 2'd1,
        MODE_PRE  = 2'd2,
        MODE_DISP = 2'd3
    } agen_mode_e;

    // True for the modes that write the address register back.
    function automatic logic mode_steps(input agen_mode_e m);
        return (m == MODE_POST) || (m == MODE_PRE);
    endfunction

endpackage

// File: rtl/cq_mask_reg.sv
// Mask register. It resets to all ones, so masking is transparent until
// software writes a value. A write lands at the clock edge, so a request in
// the same cycle still sees the old value.
module cq_mask_reg #(
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask_q
);

    // Hold the mask: load on write, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en)
            mask_q <= wr_data;
    end

    AST_MASK_RESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_q == {MASK_W{1'b1}})) else $error("mask not reset"); // R1

endmodule

// File: rtl/cq_addr_arith.sv
// Unmasked address arithmetic: An + step, An - step and An + sign-extended
// displacement. All sums wrap modulo 2^ADDR_W. Assumes DISP_W <= ADDR_W.
module cq_addr_arith #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] areg,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] sum_inc,
    output logic [ADDR_W-1:0] sum_dec,
    output logic [ADDR_W-1:0] sum_disp
);

    localparam int EXT_W = ADDR_W - DISP_W;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement to the address width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_noext
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    // Three wrapping adders that feed the mode select.
    always_comb begin
        sum_inc  = areg + STEP_V;
        sum_dec  = areg - STEP_V;
        sum_disp = areg + disp_ext;
    end

endmodule

// File: rtl/cq_mask_apply.sv
// Applies the mask to the low MASK_W bits of an address when enabled.
// Upper bits always pass through. Assumes MASK_W <= ADDR_W.
module cq_mask_apply #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [MASK_W-1:0] mask,
    input  logic              enable,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - MASK_W;

    logic [MASK_W-1:0] lo_masked;

    // AND the low field with the mask, or leave it as is when disabled.
    always_comb begin
        lo_masked = enable ? (addr_in[MASK_W-1:0] & mask) : addr_in[MASK_W-1:0];
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign addr_out = {addr_in[ADDR_W-1:MASK_W], lo_masked};
        end else begin : g_nohi
            assign addr_out = lo_masked;
        end
    endgenerate

endmodule

// File: rtl/cq_rsp_stage.sv
// Output register stage. Captures the addresses on a valid request, holds
// them otherwise, and produces the valid and write-back strobes one cycle
// after the request.
module cq_rsp_stage #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_wb,
    input  logic [ADDR_W-1:0] in_oper,
    input  logic [ADDR_W-1:0] in_new,
    output logic              out_valid,
    output logic              out_wb,
    output logic [ADDR_W-1:0] out_oper,
    output logic [ADDR_W-1:0] out_new
);

    // Strobes follow the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wb    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_wb    <= in_valid && in_wb;
        end
    end

    // Address results load only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_oper <= '0;
            out_new  <= '0;
        end else if (in_valid) begin
            out_oper <= in_oper;
            out_new  <= in_new;
        end
    end

    AST_VALID_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))) else $error("valid timing"); // R8
    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_wb |-> out_valid) else $error("wb without valid"); // R8
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_oper) && $stable(out_new)))
        else $error("outputs moved while idle"); // R8

endmodule

// File: rtl/cq_addr_gen.sv
// Masked circular-queue address generator (top). For each request it selects
// the unmasked operand and update addresses by mode, masks each one as that
// mode requires, and registers the results. Assumes MASK_W <= ADDR_W and
// DISP_W <= ADDR_W.
module cq_addr_gen
    import cq_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 16,
    parameter int DISP_W = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_en,
    input  logic [MASK_W-1:0] mask_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_areg,
    input  logic [DISP_W-1:0] req_disp,
    input  logic              req_mask_en,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_oper_addr,
    output logic [ADDR_W-1:0] rsp_areg_new,
    output logic              rsp_wb
);

    agen_mode_e        mode;
    logic [MASK_W-1:0] mask_q;
    logic [ADDR_W-1:0] sum_inc, sum_dec, sum_disp;
    logic [ADDR_W-1:0] oper_raw, new_raw, oper_fin, new_fin;
    logic              oper_msk_en, new_msk_en, steps;

    assign mode = agen_mode_e'(req_mode);

    cq_mask_reg #(.MASK_W(MASK_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .mask_q  (mask_q)
    );

    cq_addr_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP)) u_arith (
        .areg     (req_areg),
        .disp     (req_disp),
        .sum_inc  (sum_inc),
        .sum_dec  (sum_dec),
        .sum_disp (sum_disp)
    );

    // Pick the raw addresses and decide where the mask applies for each mode.
    always_comb begin
        steps       = mode_steps(mode);
        oper_raw    = req_areg;
        new_raw     = req_areg;
        oper_msk_en = req_mask_en;
        new_msk_en  = 1'b0;
        unique case (mode)
            MODE_IND: begin
                oper_raw = req_areg;
            end
            MODE_POST: begin
                oper_raw    = req_areg;
                new_raw     = sum_inc;
                oper_msk_en = 1'b0;
                new_msk_en  = req_mask_en;
            end
            MODE_PRE: begin
                oper_raw   = sum_dec;
                new_raw    = sum_dec;
                new_msk_en = req_mask_en;
            end
            MODE_DISP: begin
                oper_raw = sum_disp;
            end
            default: ;
        endcase
    end

    cq_mask_apply #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_mask_oper (
        .addr_in  (oper_raw),
        .mask     (mask_q),
        .enable   (oper_msk_en),
        .addr_out (oper_fin)
    );

    cq_mask_apply #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_mask_new (
        .addr_in  (new_raw),
        .mask     (mask_q),
        .enable   (new_msk_en),
        .addr_out (new_fin)
    );

    cq_rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_wb     (steps),
        .in_oper   (oper_fin),
        .in_new    (new_fin),
        .out_valid (rsp_valid),
        .out_wb    (rsp_wb),
        .out_oper  (rsp_oper_addr),
        .out_new   (rsp_areg_new)
    );

    generate
        if (ADDR_W > MASK_W) begin : g_hi_chk
            AST_UPPER_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
                (oper_fin[ADDR_W-1:MASK_W] == oper_raw[ADDR_W-1:MASK_W]) &&
                (new_fin[ADDR_W-1:MASK_W] == new_raw[ADDR_W-1:MASK_W]))
                else $error("upper bits altered"); // R7
        end
    endgenerate

    AST_UNMASKED_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_mask_en |-> ((oper_fin == oper_raw) && (new_fin == new_raw)))
        else $error("mask applied while disabled"); // R2
    AST_POST_OPER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_POST) |-> (oper_fin == req_areg))
        else $error("post-increment operand altered"); // R4
    AST_PRE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == MODE_PRE) |=> (rsp_oper_addr == rsp_areg_new))
        else $error("pre-decrement results differ"); // R5

endmodule

// File: tb/cq_addr_gen_bench.sv
module cq_addr_gen_bench;

    localparam int AW = 12;
    localparam int MW = 8;
    localparam int DW = 8;
    localparam int ST = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_wr_en = 1'b0;
    logic [MW-1:0] mask_wr_data = '0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic [AW-1:0] req_areg = '0;
    logic [DW-1:0] req_disp = '0;
    logic          req_mask_en = 1'b0;
    logic          rsp_valid, rsp_wb;
    logic [AW-1:0] rsp_oper_addr, rsp_areg_new;

    int n_cmp = 0;
    int n_bad = 0;
    logic [MW-1:0] cur_mask = '1;

    always #4 clk = ~clk;

    cq_addr_gen #(.ADDR_W(AW), .MASK_W(MW), .DISP_W(DW), .STEP(ST)) u_cq_addr_gen (
        .clk(clk), .rst_n(rst_n), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .req_valid(req_valid), .req_mode(req_mode), .req_areg(req_areg),
        .req_disp(req_disp), .req_mask_en(req_mask_en), .rsp_valid(rsp_valid),
        .rsp_oper_addr(rsp_oper_addr), .rsp_areg_new(rsp_areg_new), .rsp_wb(rsp_wb)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request at a negedge; check its results at the next negedge.
    task automatic do_req(input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic en, input logic [MW-1:0] mk);
        logic [AW-1:0] fm, dx, eo, en_new;
        fm = {{(AW-MW){1'b1}}, mk};
        dx = {{(AW-DW){d[DW-1]}}, d};
        case (m)
            2'd0: begin eo = en ? (a & fm) : a; en_new = a; end
            2'd1: begin eo = a; en_new = en ? ((a + AW'(ST)) & fm) : (a + AW'(ST)); end
            2'd2: begin eo = en ? ((a - AW'(ST)) & fm) : (a - AW'(ST)); en_new = eo; end
            default: begin eo = en ? ((a + dx) & fm) : (a + dx); en_new = a; end
        endcase
        req_valid = 1'b1; req_mode = m; req_areg = a; req_disp = d; req_mask_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        if (!en) begin
            check("R2 oper", rsp_oper_addr, eo);
            check("R2 new", rsp_areg_new, en_new);
        end else begin
            case (m)
                2'd0: begin check("R3 oper", rsp_oper_addr, eo); check("R3 new", rsp_areg_new, en_new); end
                2'd1: begin check("R4 oper", rsp_oper_addr, eo); check("R4 new", rsp_areg_new, en_new); end
                2'd2: begin check("R5 oper", rsp_oper_addr, eo); check("R5 new", rsp_areg_new, en_new); end
                default: begin check("R6 oper", rsp_oper_addr, eo); check("R6 new", rsp_areg_new, en_new); end
            endcase
        end
        check("R8 valid", AW'(rsp_valid), AW'(1));
        check("R8 wb", AW'(rsp_wb), AW'(m == 2'd1 || m == 2'd2));
    endtask

    task automatic write_mask(input logic [MW-1:0] v);
        mask_wr_en = 1'b1; mask_wr_data = v;
        @(negedge clk);
        mask_wr_en = 1'b0;
        cur_mask = v;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] ho, hn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of all outputs
        check("R1 valid", AW'(rsp_valid), '0);
        check("R1 wb", AW'(rsp_wb), '0);
        check("R1 oper", rsp_oper_addr, '0);
        check("R1 new", rsp_areg_new, '0);
        // R1: default mask of all ones is transparent
        do_req(2'd3, 12'hABC, 8'h85, 1'b1, 8'hFF);
        do_req(2'd1, 12'h3FE, 8'h00, 1'b1, 8'hFF);

        // R10: wrap at both ends
        do_req(2'd1, 12'hFFC, 8'h00, 1'b0, cur_mask);
        check("R10 post wrap", rsp_areg_new, 12'h000);
        do_req(2'd2, 12'h002, 8'h00, 1'b0, cur_mask);
        check("R10 pre wrap", rsp_oper_addr, 12'hFFE);
        do_req(2'd3, 12'h010, 8'h80, 1'b0, cur_mask);
        check("R10 disp wrap", rsp_oper_addr, 12'hF90);

        // R7: mask of zero keeps the upper field
        write_mask(8'h00);
        do_req(2'd0, 12'hA37, 8'h00, 1'b1, 8'h00);
        check("R7 upper", rsp_oper_addr, 12'hA00);
        do_req(2'd3, 12'h5F0, 8'h20, 1'b1, 8'h00);
        check("R7 upper disp", rsp_oper_addr, 12'h600);

        // R9: write coinciding with a request is not seen by it
        mask_wr_en = 1'b1; mask_wr_data = 8'h0F;
        do_req(2'd0, 12'h1FF, 8'h00, 1'b1, 8'h00);
        mask_wr_en = 1'b0; cur_mask = 8'h0F;
        check("R9 old mask", rsp_oper_addr, 12'h100);
        do_req(2'd0, 12'h1FF, 8'h00, 1'b1, 8'h0F);
        check("R9 new mask", rsp_oper_addr, 12'h10F);

        // R8: idle cycle holds addresses and drops strobes
        ho = rsp_oper_addr; hn = rsp_areg_new;
        @(negedge clk);
        check("R8 idle valid", AW'(rsp_valid), '0);
        check("R8 idle wb", AW'(rsp_wb), '0);
        check("R8 idle oper", rsp_oper_addr, ho);
        check("R8 idle new", rsp_areg_new, hn);

        // Sweep: three masks x every address x four modes x mask enable
        for (int k = 0; k < 3; k++) begin
            logic [MW-1:0] mk;
            mk = (k == 0) ? 8'h3F : (k == 1) ? 8'hA5 : 8'hFF;
            write_mask(mk);
            for (int a = 0; a < (1 << AW); a++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int e = 0; e < 2; e++) begin
                        do_req(2'(m), AW'(a), DW'(a * 37 + m * 11), 1'(e), mk);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule